// File: doc/BRIEF.md
# FIFO trigger-level interrupt controller

This block sits between a serial shift engine and the software that feeds it. It holds two byte queues: a transmit queue that software fills and the engine drains, and a receive queue that the engine fills and software drains. Software programs a fill threshold for each queue. The block raises interrupt status when the receive queue is full enough to be worth draining, when the transmit queue is empty enough to need a refill, when a received byte had to be dropped, and when the engine reports that a transfer has finished.

Software reaches the block through a small word-wide register port with a write strobe, a 3-bit address and a combinational read. The port carries an interrupt enable word, a status word whose bits are cleared by writing 1, a queue control word and a fill-count word. The engine connects through push and pop strobes and a one-cycle completion pulse. A single interrupt line is raised whenever any pending status bit is also enabled.

Each status bit that follows a queue level is set again on every cycle its condition holds. A clear therefore only sticks once software has drained or refilled the queue. The queue depth is a parameter and must be a power of two up to 128, for example 64 or 128.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: The enable word sits at address 0 and the status word at address 1. Both place the interrupt sources at the same bits: bit 0 receive-ready, bit 4 transmit-request, bit 8 receive-overflow, bit 12 transfer-done. All other bits read 0, and any address above 3 reads 0.
- R2: Writing the status word (address 1) clears each source bit written as 1 and leaves each bit written as 0 unchanged. A level-driven bit whose condition still holds on the cycle of the clear stays 1.
- R3: Receive-ready (bit 0) becomes 1 on the cycle after any cycle on which the receive fill count is at least the receive threshold.
- R4: Transmit-request (bit 4) becomes 1 on the cycle after any cycle on which the transmit fill count is at most the transmit threshold.
- R5: An engine push into a full receive queue drops the byte, leaves the count at the depth, and sets receive-overflow (bit 8) on the next cycle.
- R6: A one-cycle transfer-done pulse sets bit 12 on the next cycle. The bit stays set until software clears it.
- R7: The interrupt output is 1 exactly while some status bit and its enable bit are both 1, with no added delay. It stays 0 while the enable word is 0.
- R8: The control word is at address 2. The receive threshold is in bits 7:0 and the transmit threshold in bits 23:16, and both read back. Writing 1 to bit 15 empties the receive queue, and writing 1 to bit 31 empties the transmit queue, both by the next cycle. Bits 15 and 31 always read 0.
- R9: The fill-count word is at address 3. The receive count is in the low bits from bit 0 and the transmit count in the low bits from bit 16.
- R10: Each queue returns bytes in push order and shows its oldest byte on its read port. A pop from an empty queue changes nothing, a software push into a full transmit queue is dropped, and the transmit-empty output is 1 exactly when the transmit count is 0.
- R11: After reset the enable word, status word, fill counts and interrupt output are 0, and both thresholds hold three quarters of the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| host_tx_push | input | 1 | Software pushes a byte into the transmit queue |
| host_tx_byte | input | 8 | Byte to push into the transmit queue |
| host_rx_pop | input | 1 | Software pops the oldest received byte |
| host_rx_byte | output | 8 | Oldest byte in the receive queue |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_byte | output | 8 | Oldest byte in the transmit queue |
| eng_tx_empty | output | 1 | Transmit queue is empty |
| eng_rx_push | input | 1 | Engine pushes a received byte |
| eng_rx_byte | input | 8 | Received byte from the engine |
| eng_xfer_done | input | 1 | One-cycle transfer-finished pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
A fill counter that drifts from the true queue contents shows up on the next read of the fill-count word. One cycle later it shows up again as a level status bit appearing or vanishing at the wrong threshold crossing. A read pointer out of step shows a wrong byte on the queue's read port on the very cycle it happens. Because the status word can be read without side effects, the bench compares every register and both read ports on every cycle, so a wrong status or enable bit shows within a cycle. It does so against a queue-based model under long biased random traffic. Directed sequences pin down the clears that must not stick, the overflow at exactly full, and the empty pop.

// File: rtl/fifo_irq_pkg.sv
// Package: shared constants and helpers for the FIFO trigger-level interrupt
// controller. Assumes a 32-bit register word and four interrupt sources
// spaced four bits apart in the enable and status words.
package fifo_irq_pkg;

    localparam int ADDR_W     = 3;
    localparam int WORD_W     = 32;
    localparam int TRIG_W     = 8;
    localparam int NUM_SRC    = 4;
    localparam int SRC_STRIDE = 4;

    // Source indices inside the compact internal vectors
    localparam int SRC_RX_RDY = 0;
    localparam int SRC_TX_REQ = 1;
    localparam int SRC_RX_OVF = 2;
    localparam int SRC_DONE   = 3;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_IRQ_EN    = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_IRQ_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_FIFO_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_FIFO_STAT = 3'd3;

    // Field positions in the control and fill-count words
    localparam int RX_TRIG_LSB  = 0;
    localparam int RX_FLUSH_BIT = 15;
    localparam int TX_TRIG_LSB  = 16;
    localparam int TX_FLUSH_BIT = 31;
    localparam int RX_CNT_LSB   = 0;
    localparam int TX_CNT_LSB   = 16;

    // Place the compact source vector at its register bit positions
    function automatic logic [WORD_W-1:0] spread_irq(input logic [NUM_SRC-1:0] v);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            r[i*SRC_STRIDE] = v[i];
        end
        return r;
    endfunction

    // Collect the source bits from a register word into the compact vector
    function automatic logic [NUM_SRC-1:0] gather_irq(input logic [WORD_W-1:0] w);
        logic [NUM_SRC-1:0] r;
        for (int i = 0; i < NUM_SRC; i++) begin
            r[i] = w[i*SRC_STRIDE];
        end
        return r;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Module: byte_fifo
// Synchronous show-ahead FIFO with a fill counter and a flush input.
// Assumes DEPTH is a power of two. A push into a full queue is dropped and
// flagged on overflow in the same cycle. A pop from an empty queue is ignored.
// Flush wins over push and pop on the same cycle.
module byte_fifo #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty,
    output logic              overflow
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full && !flush;
    assign do_pop   = pop && !empty && !flush;
    assign overflow = push && full && !flush;
    assign pop_data = mem[rd_ptr];

    // Pointer and fill-count update, with flush emptying the queue
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write for accepted pushes
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && flush |=> empty);

    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && full && push && !pop && !flush |=> full);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && empty && pop && !push && !flush |=> empty);

endmodule

// File: rtl/fifo_ctrl_regs.sv
// Module: fifo_ctrl_regs
// Holds the two trigger thresholds and turns the flush bits of a control
// write into one-cycle flush strobes. Assumes the caller has already decoded
// the address into ctrl_we. The flush bits are never stored.
module fifo_ctrl_regs
    import fifo_irq_pkg::*;
#(
    parameter int TRIG_RST = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [TRIG_W-1:0] rx_trig_in,
    input  logic [TRIG_W-1:0] tx_trig_in,
    input  logic              rx_flush_in,
    input  logic              tx_flush_in,
    output logic [TRIG_W-1:0] rx_trig,
    output logic [TRIG_W-1:0] tx_trig,
    output logic              rx_flush,
    output logic              tx_flush
);

    // Flush strobes act on the same edge as the control write
    assign rx_flush = ctrl_we && rx_flush_in;
    assign tx_flush = ctrl_we && tx_flush_in;

    // Threshold registers with a three-quarter-depth reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_trig <= TRIG_W'(TRIG_RST);
            tx_trig <= TRIG_W'(TRIG_RST);
        end else if (ctrl_we) begin
            rx_trig <= rx_trig_in;
            tx_trig <= tx_trig_in;
        end
    end

    // R8
    trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && ctrl_we |=> (rx_trig == $past(rx_trig_in)) && (tx_trig == $past(tx_trig_in)));

endmodule

// File: rtl/irq_status_unit.sv
// Module: irq_status_unit
// Enable and write-1-to-clear status registers for the four interrupt
// sources, plus the combined request. Level sources are compared against
// the registered fill counts. Any set condition wins over a clear on the
// same cycle.
module irq_status_unit
    import fifo_irq_pkg::*;
#(
    parameter int CW = 8,
    localparam int CMP_W = (CW > TRIG_W) ? CW : TRIG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic               st_we,
    input  logic [NUM_SRC-1:0] wr_bits,
    input  logic [CW-1:0]      rx_cnt,
    input  logic [CW-1:0]      tx_cnt,
    input  logic [TRIG_W-1:0]  rx_trig,
    input  logic [TRIG_W-1:0]  tx_trig,
    input  logic               rx_ovf,
    input  logic               xfer_done,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] st_q,
    output logic               irq
);

    logic [CMP_W-1:0]   rx_cnt_x;
    logic [CMP_W-1:0]   tx_cnt_x;
    logic [CMP_W-1:0]   rx_trig_x;
    logic [CMP_W-1:0]   tx_trig_x;
    logic [NUM_SRC-1:0] set_v;
    logic [NUM_SRC-1:0] clr_v;

    assign rx_cnt_x  = CMP_W'(rx_cnt);
    assign tx_cnt_x  = CMP_W'(tx_cnt);
    assign rx_trig_x = CMP_W'(rx_trig);
    assign tx_trig_x = CMP_W'(tx_trig);

    // Collect this cycle's set conditions from levels and event pulses
    always_comb begin
        set_v             = '0;
        set_v[SRC_RX_RDY] = (rx_cnt_x >= rx_trig_x);
        set_v[SRC_TX_REQ] = (tx_cnt_x <= tx_trig_x);
        set_v[SRC_RX_OVF] = rx_ovf;
        set_v[SRC_DONE]   = xfer_done;
    end

    assign clr_v = st_we ? wr_bits : '0;

    // Status update: clear written ones, then apply set conditions
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_v) | set_v;
    end

    // Enable register load
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wr_bits;
    end

    assign irq = |(st_q & en_q);

    // R3
    rx_rdy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && (rx_cnt_x >= rx_trig_x) |=> st_q[SRC_RX_RDY]);

    // R4
    tx_req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && (tx_cnt_x <= tx_trig_x) |=> st_q[SRC_TX_REQ]);

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && rx_ovf |=> st_q[SRC_RX_OVF]);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && st_q[SRC_DONE] && !(st_we && wr_bits[SRC_DONE]) |=> st_q[SRC_DONE]);

    // R2
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && st_we && wr_bits[SRC_DONE] && !xfer_done |=> !st_q[SRC_DONE]);

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

endmodule

// File: rtl/fifo_irq_ctrl.sv
// Module: fifo_irq_ctrl (top)
// Transmit and receive byte queues with programmable trigger levels,
// per-queue flush, fill-count readout, interrupt enable and write-1-to-clear
// status, and one combined interrupt line. Assumes DEPTH is a power of two
// no larger than 128, so each fill count fits its 8-bit readout field.
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int TRIG_RST = DEPTH / 4 * 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_byte,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_byte,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_byte,
    output logic              eng_tx_empty,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_xfer_done,
    output logic              irq
);

    logic               en_we;
    logic               st_we;
    logic               ctrl_we;
    logic [NUM_SRC-1:0] wr_bits;
    logic [TRIG_W-1:0]  rx_trig;
    logic [TRIG_W-1:0]  tx_trig;
    logic               rx_flush;
    logic               tx_flush;
    logic [CW-1:0]      rx_cnt;
    logic [CW-1:0]      tx_cnt;
    logic               rx_ovf;
    logic               tx_ovf;
    logic               rx_full;
    logic               rx_empty;
    logic               tx_full;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] st_q;
    logic               unused_sink;

    // Register write decode
    assign en_we   = reg_wen && (reg_addr == ADDR_IRQ_EN);
    assign st_we   = reg_wen && (reg_addr == ADDR_IRQ_STAT);
    assign ctrl_we = reg_wen && (reg_addr == ADDR_FIFO_CTRL);
    assign wr_bits = gather_irq(reg_wdata);

    // Sink for write bits and queue flags that no register uses
    assign unused_sink = ^{reg_wdata, tx_ovf, rx_full, rx_empty, tx_full};

    fifo_ctrl_regs #(
        .TRIG_RST (TRIG_RST)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .rx_trig_in  (reg_wdata[RX_TRIG_LSB +: TRIG_W]),
        .tx_trig_in  (reg_wdata[TX_TRIG_LSB +: TRIG_W]),
        .rx_flush_in (reg_wdata[RX_FLUSH_BIT]),
        .tx_flush_in (reg_wdata[TX_FLUSH_BIT]),
        .rx_trig     (rx_trig),
        .tx_trig     (tx_trig),
        .rx_flush    (rx_flush),
        .tx_flush    (tx_flush)
    );

    byte_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (host_tx_push),
        .push_data (host_tx_byte),
        .pop       (eng_tx_pop),
        .pop_data  (eng_tx_byte),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (eng_tx_empty),
        .overflow  (tx_ovf)
    );

    byte_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_byte),
        .pop       (host_rx_pop),
        .pop_data  (host_rx_byte),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty),
        .overflow  (rx_ovf)
    );

    irq_status_unit #(
        .CW (CW)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_we     (en_we),
        .st_we     (st_we),
        .wr_bits   (wr_bits),
        .rx_cnt    (rx_cnt),
        .tx_cnt    (tx_cnt),
        .rx_trig   (rx_trig),
        .tx_trig   (tx_trig),
        .rx_ovf    (rx_ovf),
        .xfer_done (eng_xfer_done),
        .en_q      (en_q),
        .st_q      (st_q),
        .irq       (irq)
    );

    // Combinational register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_IRQ_EN:   reg_rdata = spread_irq(en_q);
            ADDR_IRQ_STAT: reg_rdata = spread_irq(st_q);
            ADDR_FIFO_CTRL: begin
                reg_rdata[RX_TRIG_LSB +: TRIG_W] = rx_trig;
                reg_rdata[TX_TRIG_LSB +: TRIG_W] = tx_trig;
            end
            ADDR_FIFO_STAT: begin
                reg_rdata[RX_CNT_LSB +: CW] = rx_cnt;
                reg_rdata[TX_CNT_LSB +: CW] = tx_cnt;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R1
    stat_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_IRQ_STAT) |-> ((reg_rdata & ~32'h0000_1111) == '0));

endmodule

// File: tb/fifo_irq_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_irq_ctrl_tb;

    localparam int DEPTH = 64;
    localparam logic [2:0] A_EN = 3'd0, A_ST = 3'd1, A_CTRL = 3'd2, A_FST = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_tx_push = 1'b0;
    logic [7:0]  host_tx_byte = '0;
    logic        host_rx_pop = 1'b0;
    logic [7:0]  host_rx_byte;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_empty;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_xfer_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model state
    logic [7:0]  mq_tx[$];
    logic [7:0]  mq_rx[$];
    logic [31:0] m_st = 0;
    logic [31:0] m_en = 0;
    int          m_rxtrig = DEPTH / 4 * 3;
    int          m_txtrig = DEPTH / 4 * 3;

    fifo_irq_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_tx_push(host_tx_push), .host_tx_byte(host_tx_byte),
        .host_rx_pop(host_rx_pop), .host_rx_byte(host_rx_byte),
        .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_empty(eng_tx_empty),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
        .eng_xfer_done(eng_xfer_done), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.2;
        v = reg_rdata;
    endtask

    // Compare every visible register and port against the model
    task automatic check_all();
        logic [31:0] v;
        rd(A_ST, v);   chk("R2 R3 R4 R5 R6 status word", v, m_st);
        rd(A_FST, v);  chk("R9 fill counts", v, 32'(mq_rx.size()) | (32'(mq_tx.size()) << 16));
        rd(A_EN, v);   chk("R1 enable word", v, m_en);
        rd(A_CTRL, v); chk("R8 control readback", v, 32'(m_rxtrig) | (32'(m_txtrig) << 16));
        chk("R7 irq", 32'(irq), 32'(|(m_st & m_en)));
        chk("R10 tx empty flag", 32'(eng_tx_empty), 32'(mq_tx.size() == 0));
        if (mq_rx.size() != 0) chk("R10 rx order", 32'(host_rx_byte), 32'(mq_rx[0]));
        if (mq_tx.size() != 0) chk("R10 tx order", 32'(eng_tx_byte), 32'(mq_tx[0]));
    endtask

    // One clock: model next state from driven inputs, edge, commit, check
    task automatic cycle();
        int rxn, txn;
        logic [31:0] set_v, clr_v, nst, nen;
        int nrx, ntx;
        logic rxf, txf;
        rxn = mq_rx.size();
        txn = mq_tx.size();
        set_v = 0; clr_v = 0;
        rxf = reg_wen && reg_addr == A_CTRL && reg_wdata[15];
        txf = reg_wen && reg_addr == A_CTRL && reg_wdata[31];
        if (rxn >= m_rxtrig) set_v |= 32'h1;
        if (txn <= m_txtrig) set_v |= 32'h10;
        if (eng_rx_push && rxn == DEPTH && !rxf) set_v |= 32'h100;
        if (eng_xfer_done) set_v |= 32'h1000;
        if (reg_wen && reg_addr == A_ST) clr_v = reg_wdata & 32'h1111;
        nst = (m_st & ~clr_v) | set_v;
        nen = (reg_wen && reg_addr == A_EN) ? (reg_wdata & 32'h1111) : m_en;
        nrx = m_rxtrig; ntx = m_txtrig;
        if (reg_wen && reg_addr == A_CTRL) begin
            nrx = int'(reg_wdata[7:0]);
            ntx = int'(reg_wdata[23:16]);
        end
        if (rxf) mq_rx.delete();
        else begin
            if (host_rx_pop && rxn > 0) void'(mq_rx.pop_front());
            if (eng_rx_push && rxn < DEPTH) mq_rx.push_back(eng_rx_byte);
        end
        if (txf) mq_tx.delete();
        else begin
            if (eng_tx_pop && txn > 0) void'(mq_tx.pop_front());
            if (host_tx_push && txn < DEPTH) mq_tx.push_back(host_tx_byte);
        end
        @(negedge clk);
        m_st = nst; m_en = nen; m_rxtrig = nrx; m_txtrig = ntx;
        reg_wen = 0; host_tx_push = 0; host_rx_pop = 0;
        eng_tx_pop = 0; eng_rx_push = 0; eng_xfer_done = 0;
        check_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wen = 1; reg_addr = a; reg_wdata = d;
        cycle();
    endtask

    task automatic eng_push(input logic [7:0] b);
        eng_rx_push = 1; eng_rx_byte = b; cycle();
    endtask

    task automatic host_push(input logic [7:0] b);
        host_tx_push = 1; host_tx_byte = b; cycle();
    endtask

    task automatic rand_phase(input int n, input int p_tp, input int p_tpop, input int p_rp, input int p_rpop);
        for (int i = 0; i < n; i++) begin
            host_tx_push  = ($urandom_range(99) < p_tp);
            host_tx_byte  = 8'($urandom);
            eng_tx_pop    = ($urandom_range(99) < p_tpop);
            eng_rx_push   = ($urandom_range(99) < p_rp);
            eng_rx_byte   = 8'($urandom);
            host_rx_pop   = ($urandom_range(99) < p_rpop);
            eng_xfer_done = ($urandom_range(99) < 3);
            if ($urandom_range(99) < 6) begin
                int k;
                k = $urandom_range(2);
                reg_wen = 1;
                reg_addr = 3'(k);
                if (k == 2) begin
                    reg_wdata = 32'($urandom_range(DEPTH)) | (32'($urandom_range(DEPTH)) << 16);
                    if ($urandom_range(5) == 0) reg_wdata[15] = 1'b1;
                    if ($urandom_range(5) == 0) reg_wdata[31] = 1'b1;
                end else begin
                    reg_wdata = $urandom;
                end
            end
            cycle();
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11 reset state, sampled while reset is held
        rd(A_EN, v);   chk("R11 reset enable", v, 32'h0);
        rd(A_ST, v);   chk("R11 reset status", v, 32'h0);
        rd(A_FST, v);  chk("R11 reset counts", v, 32'h0);
        rd(A_CTRL, v); chk("R11 reset thresholds", v, 32'h0030_0030);
        chk("R11 reset irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        cycle();

        // R1 bit positions and unused address
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, v); chk("R1 enable bits", v, 32'h0000_1111);
        rd(3'd5, v); chk("R1 unused address", v, 32'h0);
        wr(A_EN, 32'h0);

        // R2 / R3 clear versus level
        wr(A_CTRL, 32'h8000_8004);
        rd(A_CTRL, v); chk("R8 flush bits read 0", v, 32'h0000_0004);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, v); chk("R2 level bit stays after clear-all", v, 32'h0000_0010);
        for (int i = 0; i < 3; i++) eng_push(8'(8'h10 + i));
        cycle();
        rd(A_ST, v); chk("R3 below threshold", v & 32'h1, 32'h0);
        eng_push(8'h13);
        cycle();
        rd(A_ST, v); chk("R3 at threshold", v & 32'h1, 32'h1);
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R3 clear does not stick while level holds", v & 32'h1, 32'h1);
        host_rx_pop = 1; cycle();
        wr(A_ST, 32'h1);
        rd(A_ST, v); chk("R2 clear sticks after drain", v & 32'h1, 32'h0);

        // R4 transmit request
        wr(A_CTRL, 32'h0002_0004);
        for (int i = 0; i < 3; i++) host_push(8'(8'h40 + i));
        wr(A_ST, 32'h10);
        rd(A_ST, v); chk("R4 above threshold cleared", v & 32'h10, 32'h0);
        eng_tx_pop = 1; cycle();
        rd(A_ST, v); chk("R4 not yet set", v & 32'h10, 32'h0);
        cycle();
        rd(A_ST, v); chk("R4 set at threshold", v & 32'h10, 32'h10);

        // R5 overflow at exactly full
        wr(A_CTRL, 32'h0002_8004);
        for (int i = 0; i < DEPTH; i++) eng_push(8'(i));
        rd(A_ST, v); chk("R5 no overflow when just full", v & 32'h100, 32'h0);
        eng_push(8'hEE);
        rd(A_ST, v); chk("R5 overflow set", v & 32'h100, 32'h100);
        rd(A_FST, v); chk("R5 count held at depth", v & 32'hFF, 32'(DEPTH));

        // R6 / R7 transfer done and irq gating
        wr(A_EN, 32'h1000);
        wr(A_ST, 32'hFFFF_FFFF);
        chk("R7 irq low with only done enabled", 32'(irq), 32'h0);
        eng_xfer_done = 1; cycle();
        rd(A_ST, v); chk("R6 done set", v & 32'h1000, 32'h1000);
        chk("R7 irq raised", 32'(irq), 32'h1);
        repeat (3) cycle();
        rd(A_ST, v); chk("R6 done sticky", v & 32'h1000, 32'h1000);
        wr(A_ST, 32'h1000);
        rd(A_ST, v); chk("R6 done cleared", v & 32'h1000, 32'h0);
        chk("R7 irq dropped", 32'(irq), 32'h0);

        // R8 flush both queues
        wr(A_CTRL, 32'h8002_8004);
        rd(A_FST, v); chk("R8 both queues empty", v, 32'h0);

        // R10 transmit overfill, order and empty pop
        wr(A_EN, 32'h0);
        for (int i = 0; i <= DEPTH; i++) host_push(8'(i) ^ 8'hA5);
        rd(A_FST, v); chk("R10 tx push to full dropped", v >> 16, 32'(DEPTH));
        chk("R10 tx head is first byte", 32'(eng_tx_byte), 32'hA5);
        for (int i = 0; i <= DEPTH; i++) begin
            eng_tx_pop = 1; cycle();
        end
        rd(A_FST, v); chk("R10 pop on empty ignored", v >> 16, 32'h0);

        // Biased random traffic
        rand_phase(800, 70, 30, 70, 30);
        rand_phase(800, 30, 70, 30, 70);
        rand_phase(800, 90, 10, 90, 5);
        rand_phase(800, 50, 50, 50, 50);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule